// File: doc/BRIEF.md
# Sector Write-Protection Controller

This block holds one write-protect flag for every physical sector of a 512 KB flash array and decides whether a program or erase request may touch the array. The sectors are not all the same size. The lower part of the array is made of large, uniform sectors. The topmost large region is split into four smaller sectors: a half, two eighths and a quarter, in that order going up the address space. The controller converts any byte address into a sector index. From that index it answers two questions: whether the sector at a given address is protected, and whether an erase of a 4 KB, 32 KB or 64 KB span, or of the whole chip, touches any protected sector.

An upstream command decoder frames the serial protocol and sends the controller one-cycle strobes. Each strobe carries an operation code, an address and a data byte, plus the current write-enable latch state. The controller then applies:

- single-sector lock and unlock requests;
- status-byte writes that can lock or unlock all sectors at once;
- changes to a lock bit that freezes all protect flags.

That lock bit combines with the write-protect pin to give two lock levels:

- **Soft lock:** the lock bit is set and the pin is released. A later status write can still clear the lock bit.
- **Hard lock:** the lock bit is set and the pin is asserted. All protection changes are refused.

Top module: `sector_guard`

## Requirements
- R1: After reset every protect flag is 1, `sprl_o` is 0, `swp_o` is 2'b11 and `q_byte_o` is 8'hFF for every address.
- R2: Sector index N is addressed as follows:
  - N from 0 to 6 covers 64 KB starting at N×10000h.
  - Sector 7 is 070000h–077FFFh.
  - Sector 8 is 078000h–079FFFh.
  - Sector 9 is 07A000h–07BFFFh.
  - Sector 10 is 07C000h–07FFFFh.
  
  `q_prot_o` reports the flag of the sector containing `q_addr_i`.
- R3: A strobe with `cmd_op_i`=2'd1 (lock sector) sets the addressed sector's flag, and one with `cmd_op_i`=2'd2 (unlock sector) clears it. Both require `wel_i`=1 and `sprl_o`=0. The effect is visible the cycle after the strobe. With `wel_i`=0, no strobe changes any state.
- R4: While `sprl_o`=1, lock-sector and unlock-sector strobes leave every flag unchanged.
- R5: A status write (`cmd_op_i`=2'd3, `wel_i`=1) made while `sprl_o`=0 behaves as follows:
  - It loads `sprl_o` from data bit 7.
  - Data bits 5:2 = 4'b1111 set every flag.
  - Data bits 5:2 = 4'b0000 clear every flag.
  - Any other value of bits 5:2 leaves the flags unchanged.
- R6: A status write made while `sprl_o`=1 and `wp_i`=0 loads `sprl_o` from data bit 7 and never changes a flag, whatever bits 5:2 hold.
- R7: With `wp_i`=1, the lock bit can only rise. A status write made while `sprl_o`=1 and `wp_i`=1 is ignored entirely.
- R8: `er_reject_o` is 1 when any sector overlapping the erase span holds a protected flag. The span is selected by `er_kind_i`:
  - 2'd0 is 4 KB, 2'd1 is 32 KB and 2'd2 is 64 KB. The span is aligned down from `er_addr_i`, so its low address bits are ignored.
  - 2'd3 is the whole chip, rejected if any sector is protected.
- R9: `q_byte_o` is 8'hFF when the queried sector is protected and 8'h00 otherwise.
- R10: `swp_o` is 2'b00 when no flag is set, 2'b11 when all are set and 2'b01 otherwise.
- R11: `hw_lock_o` is 1 exactly when `wp_i`=1 and `sprl_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_i | input | 1 | Write-protect pin, 1 = asserted |
| wel_i | input | 1 | Write-enable latch state from the command decoder |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_op_i | input | 2 | 1 lock sector, 2 unlock sector, 3 status write |
| cmd_addr_i | input | 19 | Byte address for sector commands |
| cmd_data_i | input | 8 | Status write data byte |
| q_addr_i | input | 19 | Address for the protection query |
| q_prot_o | output | 1 | Flag of the queried sector |
| q_byte_o | output | 8 | Protection readout byte for the queried sector |
| er_addr_i | input | 19 | Address inside the erase span |
| er_kind_i | input | 2 | Erase size: 0 4 KB, 1 32 KB, 2 64 KB, 3 chip |
| er_reject_o | output | 1 | Erase span covers a protected sector |
| sprl_o | output | 1 | Lock bit freezing the protect flags |
| swp_o | output | 2 | Protection summary |
| hw_lock_o | output | 1 | Hard lock active |

## Verification
The embedded properties assume the command decoder presents `cmd_op_i`, `cmd_addr_i` and `cmd_data_i` stable together with a single-cycle `cmd_valid_i`. They also assume `wel_i` reflects the latch in that same cycle. The bench drives each command for exactly one cycle on a falling edge, then returns the strobe low. It changes `wp_i` only between commands, so no strobe meets a pin edge. The sector map and the erase decoder are swept at every 4 KB step with a single sector protected at a time. Lock transitions are walked through both pin states.

// File: rtl/sg_pkg.sv
package sg_pkg;
   typedef enum logic [1:0] {
      OP_IDLE      = 2'd0,
      OP_LOCK_ONE  = 2'd1,
      OP_FREE_ONE  = 2'd2,
      OP_STAT_WR   = 2'd3
   } sg_op_e;

   typedef enum logic [1:0] {
      ER_SMALL = 2'd0,
      ER_MID   = 2'd1,
      ER_LARGE = 2'd2,
      ER_WHOLE = 2'd3
   } sg_er_e;
endpackage

// File: rtl/sg_sector_decode.sv
module sg_sector_decode #(
   parameter int ADDR_W = 19,
   parameter int BIG_W  = 16,
   localparam int NUM_BIG = (1 << (ADDR_W - BIG_W)) - 1,
   localparam int NSECT   = NUM_BIG + 4,
   localparam int IDX_W   = $clog2(NSECT)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [IDX_W-1:0]  idx_o
);
   logic [ADDR_W-BIG_W-1:0] region;
   logic [2:0]              sub;

   assign region = addr_i[ADDR_W-1:BIG_W];
   assign sub    = addr_i[BIG_W-1 -: 3];

   always_comb begin
      if (int'(region) != NUM_BIG) begin
         idx_o = IDX_W'(region);
      end else begin
         unique casez (sub)
            3'b0??:  idx_o = IDX_W'(NUM_BIG);
            3'b100:  idx_o = IDX_W'(NUM_BIG + 1);
            3'b101:  idx_o = IDX_W'(NUM_BIG + 2);
            default: idx_o = IDX_W'(NUM_BIG + 3);
         endcase
      end
   end
endmodule

// File: rtl/sg_span_check.sv
module sg_span_check
   import sg_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int BIG_W   = 16,
   parameter int SMALL_W = 12,
   parameter int MID_W   = 15,
   localparam int NUM_BIG = (1 << (ADDR_W - BIG_W)) - 1,
   localparam int NSECT   = NUM_BIG + 4
) (
   input  logic [ADDR_W-1:0] er_addr_i,
   input  sg_er_e            er_kind_i,
   input  logic [NSECT-1:0]  prot_i,
   output logic              reject_o
);
   function automatic int sect_lo(int s);
      int base;
      base = NUM_BIG << BIG_W;
      if (s < NUM_BIG)       return s << BIG_W;
      else if (s == NUM_BIG) return base;
      else if (s == NUM_BIG + 1) return base + (1 << (BIG_W - 1));
      else if (s == NUM_BIG + 2) return base + (5 << (BIG_W - 3));
      else                   return base + (3 << (BIG_W - 2));
   endfunction

   function automatic int sect_hi(int s);
      if (s == NSECT - 1) return (1 << ADDR_W) - 1;
      else                return sect_lo(s + 1) - 1;
   endfunction

   logic [ADDR_W-1:0] size_m1, span_lo, span_hi;
   logic [NSECT-1:0]  overlap;

   always_comb begin
      unique case (er_kind_i)
         ER_SMALL: size_m1 = ADDR_W'((1 << SMALL_W) - 1);
         ER_MID:   size_m1 = ADDR_W'((1 << MID_W) - 1);
         ER_LARGE: size_m1 = ADDR_W'((1 << BIG_W) - 1);
         default:  size_m1 = '1;
      endcase
   end

   assign span_lo = er_addr_i & ~size_m1;
   assign span_hi = span_lo | size_m1;

   for (genvar s = 0; s < NSECT; s++) begin : g_sect
      localparam logic [ADDR_W-1:0] LO = ADDR_W'(sect_lo(s));
      localparam logic [ADDR_W-1:0] HI = ADDR_W'(sect_hi(s));
      assign overlap[s] = (LO <= span_hi) && (HI >= span_lo);
   end

   assign reject_o = |(overlap & prot_i);
endmodule

// File: rtl/sg_prot_regs.sv
module sg_prot_regs
   import sg_pkg::*;
#(
   parameter int NSECT = 11,
   localparam int IDX_W = $clog2(NSECT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wp_i,
   input  logic             wel_i,
   input  logic             cmd_valid_i,
   input  sg_op_e           cmd_op_i,
   input  logic [IDX_W-1:0] cmd_idx_i,
   input  logic [7:0]       cmd_data_i,
   output logic [NSECT-1:0] prot_o,
   output logic             sprl_o
);
   logic [NSECT-1:0] prot_q;
   logic             sprl_q;
   logic [3:0]       glob;

   assign glob = cmd_data_i[5:2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prot_q <= '1;
         sprl_q <= 1'b0;
      end else if (cmd_valid_i && wel_i) begin
         unique case (cmd_op_i)
            OP_LOCK_ONE: if (!sprl_q) prot_q[cmd_idx_i] <= 1'b1;
            OP_FREE_ONE: if (!sprl_q) prot_q[cmd_idx_i] <= 1'b0;
            OP_STAT_WR: begin
               if (!sprl_q) begin
                  if (glob == 4'hF)      prot_q <= '1;
                  else if (glob == 4'h0) prot_q <= '0;
                  sprl_q <= cmd_data_i[7];
               end else if (!wp_i) begin
                  sprl_q <= cmd_data_i[7];
               end
            end
            default: ;
         endcase
      end
   end

   assign prot_o = prot_q;
   assign sprl_o = sprl_q;

   a_r3_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && wel_i && !sprl_q && cmd_op_i == OP_LOCK_ONE)
      |=> prot_q[$past(cmd_idx_i)]);
   a_r3_free_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && wel_i && !sprl_q && cmd_op_i == OP_FREE_ONE)
      |=> !prot_q[$past(cmd_idx_i)]);
   a_r3_no_wel_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_valid_i || !wel_i) |=> ($stable(prot_q) && $stable(sprl_q)));
   a_r4_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      sprl_q |=> $stable(prot_q));
   a_r5_global_set: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && wel_i && !sprl_q && cmd_op_i == OP_STAT_WR && glob == 4'hF)
      |=> (&prot_q));
   a_r7_hard_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sprl_q && wp_i) |=> sprl_q);
endmodule

// File: rtl/sector_guard.sv
module sector_guard
   import sg_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int BIG_W   = 16,
   parameter int SMALL_W = 12,
   parameter int MID_W   = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_i,
   input  logic              wel_i,
   input  logic              cmd_valid_i,
   input  logic [1:0]        cmd_op_i,
   input  logic [ADDR_W-1:0] cmd_addr_i,
   input  logic [7:0]        cmd_data_i,
   input  logic [ADDR_W-1:0] q_addr_i,
   output logic              q_prot_o,
   output logic [7:0]        q_byte_o,
   input  logic [ADDR_W-1:0] er_addr_i,
   input  logic [1:0]        er_kind_i,
   output logic              er_reject_o,
   output logic              sprl_o,
   output logic [1:0]        swp_o,
   output logic              hw_lock_o
);
   localparam int NUM_BIG = (1 << (ADDR_W - BIG_W)) - 1;
   localparam int NSECT   = NUM_BIG + 4;
   localparam int IDX_W   = $clog2(NSECT);

   if (ADDR_W <= BIG_W) begin : g_bad_addr
      $error("ADDR_W must exceed BIG_W");
   end
   if (!(SMALL_W < MID_W && MID_W < BIG_W)) begin : g_bad_erase
      $error("erase sizes must grow SMALL_W < MID_W < BIG_W");
   end
   if (BIG_W - 3 < SMALL_W) begin : g_bad_split
      $error("smallest split sector must hold a small erase span");
   end

   logic [IDX_W-1:0] cmd_idx, q_idx;
   logic [NSECT-1:0] prot;
   logic             all_p, none_p;

   sg_sector_decode #(.ADDR_W(ADDR_W), .BIG_W(BIG_W)) u_dec_cmd (
      .addr_i(cmd_addr_i), .idx_o(cmd_idx));

   sg_sector_decode #(.ADDR_W(ADDR_W), .BIG_W(BIG_W)) u_dec_q (
      .addr_i(q_addr_i), .idx_o(q_idx));

   sg_prot_regs #(.NSECT(NSECT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .wel_i(wel_i),
      .cmd_valid_i(cmd_valid_i), .cmd_op_i(sg_op_e'(cmd_op_i)),
      .cmd_idx_i(cmd_idx), .cmd_data_i(cmd_data_i),
      .prot_o(prot), .sprl_o(sprl_o));

   sg_span_check #(.ADDR_W(ADDR_W), .BIG_W(BIG_W), .SMALL_W(SMALL_W), .MID_W(MID_W)) u_span (
      .er_addr_i(er_addr_i), .er_kind_i(sg_er_e'(er_kind_i)),
      .prot_i(prot), .reject_o(er_reject_o));

   assign q_prot_o  = prot[q_idx];
   assign q_byte_o  = {8{q_prot_o}};
   assign all_p     = &prot;
   assign none_p    = ~|prot;
   assign swp_o     = all_p ? 2'b11 : (none_p ? 2'b00 : 2'b01);
   assign hw_lock_o = wp_i & sprl_o;

   a_r10_summary_legal: assert property (@(posedge clk) disable iff (!rst_n)
      swp_o != 2'b10);
   a_r8_chip_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (er_kind_i == 2'd3 && swp_o != 2'b00) |-> er_reject_o);
   a_r9_byte_mirrors: assert property (@(posedge clk) disable iff (!rst_n)
      (q_byte_o == 8'hFF) || (q_byte_o == 8'h00));
endmodule

// File: tb/sector_guard_tb.sv
module sector_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wp_i = 1'b0, wel_i = 1'b0, cmd_valid_i = 1'b0;
   logic [1:0]  cmd_op_i = '0;
   logic [18:0] cmd_addr_i = '0, q_addr_i = '0, er_addr_i = '0;
   logic [7:0]  cmd_data_i = '0;
   logic [1:0]  er_kind_i = '0;
   logic        q_prot_o, er_reject_o, sprl_o, hw_lock_o;
   logic [7:0]  q_byte_o;
   logic [1:0]  swp_o;

   int n_run = 0, n_fail = 0;
   bit finished = 0;
   bit m_prot [11];
   bit m_sprl;
   int lo_tab [11] = '{32'h00000, 32'h10000, 32'h20000, 32'h30000, 32'h40000, 32'h50000,
                       32'h60000, 32'h70000, 32'h78000, 32'h7A000, 32'h7C000};

   always #5 clk = ~clk;

   sector_guard dut_i (
      .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .wel_i(wel_i), .cmd_valid_i(cmd_valid_i),
      .cmd_op_i(cmd_op_i), .cmd_addr_i(cmd_addr_i), .cmd_data_i(cmd_data_i),
      .q_addr_i(q_addr_i), .q_prot_o(q_prot_o), .q_byte_o(q_byte_o),
      .er_addr_i(er_addr_i), .er_kind_i(er_kind_i), .er_reject_o(er_reject_o),
      .sprl_o(sprl_o), .swp_o(swp_o), .hw_lock_o(hw_lock_o));

   function automatic int hi_of(int k);
      return (k == 10) ? 32'h7FFFF : lo_tab[k+1] - 1;
   endfunction

   function automatic int sect_of(int a);
      int r = 0;
      for (int k = 0; k < 11; k++) if (a >= lo_tab[k]) r = k;
      return r;
   endfunction

   function automatic int exp_swp();
      int c = 0;
      for (int k = 0; k < 11; k++) c += m_prot[k];
      return (c == 0) ? 0 : ((c == 11) ? 3 : 1);
   endfunction

   function automatic int exp_reject(int a, int kind);
      int sz, s, e;
      bit r = 0;
      sz = (kind == 0) ? 4096 : (kind == 1) ? 32768 : (kind == 2) ? 65536 : 524288;
      s = a - (a % sz);
      e = s + sz - 1;
      for (int k = 0; k < 11; k++)
         if (m_prot[k] && lo_tab[k] <= e && hi_of(k) >= s) r = 1;
      return r;
   endfunction

   task automatic check(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_cmd(int op, int addr, int data);
      @(negedge clk);
      cmd_valid_i = 1'b1; cmd_op_i = 2'(op); cmd_addr_i = 19'(addr); cmd_data_i = 8'(data);
      if (wel_i) begin
         if (op == 1 && !m_sprl) m_prot[sect_of(addr)] = 1;
         if (op == 2 && !m_sprl) m_prot[sect_of(addr)] = 0;
         if (op == 3) begin
            if (!m_sprl) begin
               if (((data >> 2) & 15) == 15) foreach (m_prot[k]) m_prot[k] = 1;
               if (((data >> 2) & 15) == 0)  foreach (m_prot[k]) m_prot[k] = 0;
               m_sprl = data[7];
            end else if (!wp_i) m_sprl = data[7];
         end
      end
      @(negedge clk);
      cmd_valid_i = 1'b0;
   endtask

   task automatic check_state(string req);
      check({req, " sprl"}, sprl_o, m_sprl);
      check({req, " summary"}, swp_o, exp_swp());
      for (int k = 0; k < 11; k++) begin
         q_addr_i = 19'(lo_tab[k]);
         #1;
         check({req, " flag"}, q_prot_o, m_prot[k]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      foreach (m_prot[k]) m_prot[k] = 1;
      m_sprl = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_state("R1");
      check("R1 byte", q_byte_o, 8'hFF);
      check("R11 hw lock", hw_lock_o, 0);

      wel_i = 1'b1;
      do_cmd(3, 0, 8'h00); // R5 global unprotect
      check_state("R5 global clear");

      // R2 R3 R8 R9 R10 sweep with one sector protected
      for (int k = 0; k < 11; k++) begin
         do_cmd(1, lo_tab[k], 0);
         check("R10 some", swp_o, 1);
         for (int a = 0; a < 32'h80000; a += 4096) begin
            q_addr_i = 19'(a + 4095);
            #1;
            check("R2 map", q_prot_o, m_prot[sect_of(a + 4095)]);
            check("R9 byte", q_byte_o, m_prot[sect_of(a + 4095)] ? 8'hFF : 8'h00);
            for (int kind = 0; kind < 3; kind++) begin
               er_kind_i = 2'(kind); er_addr_i = 19'(a + 12);
               #1;
               check("R8 span", er_reject_o, exp_reject(a + 12, kind));
            end
         end
         er_kind_i = 2'd3; #1;
         check("R8 chip", er_reject_o, 1);
         do_cmd(2, hi_of(k), 0);
         check("R3 unlock", swp_o, 0);
      end
      er_kind_i = 2'd3; #1;
      check("R8 chip clear", er_reject_o, 0);

      wel_i = 1'b0;
      do_cmd(1, 32'h30000, 0);
      do_cmd(3, 8'h80 | 8'h3C, 8'hBC);
      check_state("R3 no wel");
      wel_i = 1'b1;

      do_cmd(3, 0, 8'h14); // R5 other field
      check_state("R5 other pattern");
      do_cmd(1, 32'h20000, 0);
      do_cmd(3, 0, 8'h94); // sprl on, no global
      check_state("R5 sprl set");
      do_cmd(2, 32'h20000, 0);
      do_cmd(1, 32'h7C000, 0);
      check_state("R4 frozen");
      do_cmd(3, 0, 8'hBC);
      check_state("R6 no global");
      do_cmd(3, 0, 8'h3C);
      check_state("R6 clear sprl");

      wp_i = 1'b1;
      do_cmd(3, 0, 8'h80);
      check_state("R7 rise under pin");
      #1 check("R11 hw lock on", hw_lock_o, 1);
      do_cmd(3, 0, 8'h00);
      do_cmd(2, 32'h20000, 0);
      check_state("R7 hard lock");
      wp_i = 1'b0;
      #1 check("R11 hw lock off", hw_lock_o, 0);
      do_cmd(3, 0, 8'h00);
      check_state("R6 soft unlock");
      do_cmd(3, 0, 8'h00);
      check_state("R5 clear after unlock");
      do_cmd(3, 0, 8'h3C);
      check_state("R5 global set");

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule